// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Phase

A compact stored-program processor that keeps code and data in one shared 16-bit memory and does all of its arithmetic in a single accumulator. Every instruction word carries an opcode and a direct memory address. Each instruction goes through the same cycle. A fetch phase stages the word through an address register and a buffer register. An execute phase follows. A dedicated interrupt phase then decides whether to continue with the next fetch or to divert into a handler.

The core drives a synchronous memory port with one cycle of read latency. It also has a level-sensitive interrupt request input and a one-cycle acknowledge output. Taking an interrupt saves the program counter and the accumulator into two fixed memory words and jumps to a fixed handler entry. Further requests are masked until the handler executes a return. A request that arrives while the mask is set is not lost. As long as the line stays high, it is taken in the first interrupt phase after the return.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and after it is released, the program counter, accumulator and interrupt mask are zero. The first instruction is read from address 0x000, and no write or acknowledge appears before that.
- R2: An instruction word holds the opcode in bits 15:12 and the operand address in bits 11:0. Fetch takes four cycles. The read address equals the program counter in the second fetch cycle, and the counter then advances by one.
- R3: Opcode 0x1 copies the addressed word into the accumulator. Opcode 0x5 adds the addressed word to the accumulator, modulo 2^16. Each takes three execute cycles and issues its read in the first one.
- R4: Opcode 0x2 writes the accumulator to the operand address in its single execute cycle.
- R5: Opcode 0x8 loads the program counter with the operand address in one execute cycle. The next fetch reads from that address.
- R6: Opcode 0x0 stops the core for good. After it there is no memory write and no acknowledge.
- R7: Opcodes other than 0x0, 0x1, 0x2, 0x5, 0x8 and 0x9 take one execute cycle and change no state.
- R8: One interrupt-phase cycle follows every execute phase other than halt. If the request is high and the mask is clear, the acknowledge pulses for one cycle, and in that cycle the program counter is written to 0x000. The next cycle writes the accumulator to 0x001. The following fetch reads from 0x010.
- R9: Taking an interrupt sets the mask. While it is set, a high request is not acknowledged. A request that is still high is taken in the interrupt phase that directly follows the return.
- R10: Opcode 0x9 takes four execute cycles. It reads 0x000 and 0x001, restores the program counter and accumulator from them, and clears the mask.
- R11: No memory write and no acknowledge appear in any cycle other than a store execute cycle or the two context-save cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address for the current cycle |
| memWdata | output | 16 | Write data, valid when memWe is high |
| memRdata | input | 16 | Read data, returned one cycle after the address |
| memWe | output | 1 | Memory write enable |
| irqReq | input | 1 | Interrupt request, level sensitive |
| irqAck | output | 1 | One-cycle acknowledge of a taken interrupt |

## Verification
The embedded properties check, on every cycle, the local shape of interrupt entry. An acknowledge only follows an unmasked request. It coincides with the program-counter save to 0x000, is followed by the accumulator save to 0x001, and leads to a fetch from 0x010. The same properties check that halt is permanent and quiet, and that the program counter has at most one update source. Only the bench's cycle-accurate reference model, running a real program, can show the following: that loads, wrapping adds and stores leave the right values; that jumps skip code; that unknown opcodes do nothing; and that a request raised during a handler is held off and then serviced right after the return, with the interrupted program resuming with its accumulator intact.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Opcode values (bits 15:12 of an instruction word)
  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_ADD   = 4'h5;
  localparam logic [3:0] OPC_JUMP  = 4'h8;
  localparam logic [3:0] OPC_RETI  = 4'h9;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2, ST_F3,
    ST_EXEC, ST_MEM1, ST_MEM2,
    ST_RET1, ST_RET2, ST_RET3,
    ST_INTCHK, ST_SAVE0, ST_SAVE1,
    ST_HALT
  } cpuState_e;

  typedef enum logic [1:0] {
    ADR_MAR     = 2'd0,
    ADR_PCSLOT  = 2'd1,
    ADR_ACCSLOT = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     marLdPc;
    logic     marLdMbr;
    logic     pcInc;
    logic     pcLdMar;
    logic     pcLdMbr;
    logic     pcLdVec;
    logic     mbrLd;
    logic     irLd;
    logic     accLdMbr;
    logic     accAddMbr;
    logic     memWe;
    logic     wdPc;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int PC_SLOT  = 0,
  parameter int ACC_SLOT = 1,
  parameter int VEC_ADDR = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              st,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-ADDR_W-1:0] irOp
);

  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      mbr  <= '0;
      acc  <= '0;
      irOp <= '0;
    end else begin
      if (st.marLdPc)       mar <= pc;
      else if (st.marLdMbr) mar <= mbr[ADDR_W-1:0];

      if (st.pcInc)        pc <= pc + 1'b1;
      else if (st.pcLdMar) pc <= mar;
      else if (st.pcLdMbr) pc <= mbr[ADDR_W-1:0];
      else if (st.pcLdVec) pc <= ADDR_W'(VEC_ADDR);

      if (st.mbrLd) mbr  <= memRdata;
      if (st.irLd)  irOp <= mbr[DATA_W-1:ADDR_W];

      if (st.accLdMbr)       acc <= mbr;
      else if (st.accAddMbr) acc <= acc + mbr;
    end
  end

  always_comb begin
    case (st.addrSel)
      ADR_PCSLOT:  memAddr = ADDR_W'(PC_SLOT);
      ADR_ACCSLOT: memAddr = ADDR_W'(ACC_SLOT);
      default:     memAddr = mar;
    endcase
  end

  assign memWdata = st.wdPc ? {{OP_W{1'b0}}, pc} : acc;

  AST_PC_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.pcInc, st.pcLdMar, st.pcLdMbr, st.pcLdVec})); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    st.pcInc |=> pc == ADDR_W'($past(pc) + 1'b1)); // R2

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] irOp,
  input  logic            irqReq,
  output ctrlStrobe_t     st,
  output logic            irqAck
);

  cpuState_e state, nxt;
  logic      intMask;
  logic      takeIrq;

  assign takeIrq = (state == ST_INTCHK) && irqReq && !intMask;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      ST_F0: begin st.marLdPc = 1'b1; nxt = ST_F1; end
      ST_F1: begin st.pcInc = 1'b1; st.addrSel = ADR_MAR; nxt = ST_F2; end
      ST_F2: begin st.mbrLd = 1'b1; nxt = ST_F3; end
      ST_F3: begin st.irLd = 1'b1; st.marLdMbr = 1'b1; nxt = ST_EXEC; end
      ST_EXEC: begin
        case (irOp)
          OP_W'(OPC_LOAD), OP_W'(OPC_ADD): begin
            st.addrSel = ADR_MAR;
            nxt        = ST_MEM1;
          end
          OP_W'(OPC_STORE): begin
            st.memWe = 1'b1;
            nxt      = ST_INTCHK;
          end
          OP_W'(OPC_JUMP): begin
            st.pcLdMar = 1'b1;
            nxt        = ST_INTCHK;
          end
          OP_W'(OPC_RETI): begin
            st.addrSel = ADR_PCSLOT;
            nxt        = ST_RET1;
          end
          OP_W'(OPC_HALT): nxt = ST_HALT;
          default:         nxt = ST_INTCHK;
        endcase
      end
      ST_MEM1: begin st.mbrLd = 1'b1; nxt = ST_MEM2; end
      ST_MEM2: begin
        if (irOp == OP_W'(OPC_ADD)) st.accAddMbr = 1'b1;
        else                        st.accLdMbr  = 1'b1;
        nxt = ST_INTCHK;
      end
      ST_RET1: begin st.addrSel = ADR_ACCSLOT; st.mbrLd = 1'b1; nxt = ST_RET2; end
      ST_RET2: begin st.mbrLd = 1'b1; st.pcLdMbr = 1'b1; nxt = ST_RET3; end
      ST_RET3: begin st.accLdMbr = 1'b1; nxt = ST_INTCHK; end
      ST_INTCHK: nxt = takeIrq ? ST_SAVE0 : ST_F0;
      ST_SAVE0: begin
        st.addrSel = ADR_PCSLOT;
        st.memWe   = 1'b1;
        st.wdPc    = 1'b1;
        nxt        = ST_SAVE1;
      end
      ST_SAVE1: begin
        st.addrSel = ADR_ACCSLOT;
        st.memWe   = 1'b1;
        st.pcLdVec = 1'b1;
        nxt        = ST_F0;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_F0;
      intMask <= 1'b0;
    end else begin
      state <= nxt;
      if (takeIrq)                intMask <= 1'b1;
      else if (state == ST_RET3)  intMask <= 1'b0;
    end
  end

  assign irqAck = (state == ST_SAVE0);

  AST_ACK_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    irqAck |-> $past(irqReq && !intMask)); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |-> (!st.memWe && !irqAck)); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> (state == ST_HALT)); // R6

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int PC_SLOT  = 0,
  parameter int ACC_SLOT = 1,
  parameter int VEC_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  input  logic              irqReq,
  output logic              irqAck
);

  localparam int OP_W = DATA_W - ADDR_W;

  ctrlStrobe_t     strobes;
  logic [OP_W-1:0] irOp;

  acc_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .irOp   (irOp),
    .irqReq (irqReq),
    .st     (strobes),
    .irqAck (irqAck)
  );

  acc_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PC_SLOT  (PC_SLOT),
    .ACC_SLOT (ACC_SLOT),
    .VEC_ADDR (VEC_ADDR)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .st       (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp)
  );

  assign memWe = strobes.memWe;

  AST_ACK_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
    irqAck |-> (memWe && memAddr == ADDR_W'(PC_SLOT))); // R8

  AST_ACC_SAVE_NEXT: assert property (@(posedge clk) disable iff (rst)
    irqAck |=> (memWe && memAddr == ADDR_W'(ACC_SLOT))); // R8

  AST_VECTOR_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(irqAck, 3) |-> (memAddr == ADDR_W'(VEC_ADDR))); // R8

endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memWe;
  logic        irqReq = 1'b0;
  logic        irqAck;

  logic [15:0] ramArr [0:4095];
  logic [15:0] refMem [0:4095];

  int checks = 0;
  int errors = 0;
  int ackCount = 0;
  bit modelHalted = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  acc_cpu dut_i (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memWe    (memWe),
    .irqReq   (irqReq),
    .irqAck   (irqAck)
  );

  // Synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (memWe) ramArr[memAddr] <= memWdata;
    memRdata <= ramArr[memAddr];
  end

  always @(negedge clk) if (!rst && irqAck === 1'b1) ackCount++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic stepIdle(input string req);
    @(negedge clk);
    chk(memWe === 1'b0, req, "memWe", 32'(memWe), 0);
    chk(irqAck === 1'b0, req, "irqAck", 32'(irqAck), 0);
  endtask

  task automatic stepRead(input logic [11:0] a, input string req);
    @(negedge clk);
    chk(memWe === 1'b0, req, "memWe on read", 32'(memWe), 0);
    chk(irqAck === 1'b0, req, "irqAck on read", 32'(irqAck), 0);
    chk(memAddr === a, req, "read address", 32'(memAddr), 32'(a));
  endtask

  task automatic stepWrite(input logic [11:0] a, input logic [15:0] d,
                           input logic ack, input string req);
    @(negedge clk);
    chk(memWe === 1'b1, req, "memWe on write", 32'(memWe), 1);
    chk(memAddr === a, req, "write address", 32'(memAddr), 32'(a));
    chk(memWdata === d, req, "write data", 32'(memWdata), 32'(d));
    chk(irqAck === ack, req, "irqAck on write", 32'(irqAck), 32'(ack));
  endtask

  task automatic put(input int a, input logic [15:0] v);
    ramArr[a] = v;
    refMem[a] = v;
  endtask

  // Program image
  initial begin
    for (int i = 0; i < 4096; i++) begin
      ramArr[i] = 16'h0000;
      refMem[i] = 16'h0000;
    end
    put(12'h000, 16'h8020);               // jump to main
    put(12'h010, 16'h1180);               // handler: load counter
    put(12'h011, 16'h5181);               // add one
    put(12'h012, 16'h2180);               // store counter
    put(12'h013, 16'h9000);               // return
    put(12'h020, 16'h1100);               // load
    put(12'h021, 16'h5101);               // add, wraps
    put(12'h022, 16'h2050);               // store
    put(12'h023, 16'h3ABC);               // unknown opcode
    put(12'h024, 16'h8030);               // jump over next
    put(12'h025, 16'h2051);               // must be skipped
    for (int i = 0; i < 10; i++) begin
      put(12'h030 + 2*i, 16'h5101);
      put(12'h031 + 2*i, 16'h2052 + 16'(i));
    end
    put(12'h044, 16'hF123);               // unknown opcode
    put(12'h045, 16'h1050);               // load back
    put(12'h046, 16'h2060);               // store copy
    put(12'h047, 16'h0000);               // halt
    put(12'h100, 16'h7FF0);
    put(12'h101, 16'h9013);
    put(12'h181, 16'h0001);
  end

  // Behavioural cycle-accurate reference model
  initial begin : refModel
    logic [11:0] pc;
    logic [15:0] acc;
    logic [15:0] ir;
    bit          mask;
    pc = '0; acc = '0; mask = 1'b0;
    wait (rst === 1'b0);
    forever begin
      stepIdle("R11 fetch0");
      stepRead(pc, "R2 fetch address");
      stepIdle("R11 fetch2");
      stepIdle("R11 fetch3");
      ir = refMem[pc];
      pc = pc + 12'd1;
      case (ir[15:12])
        4'h1, 4'h5: begin
          stepRead(ir[11:0], "R3 operand read");
          stepIdle("R3 wait");
          stepIdle("R3 update");
          if (ir[15:12] == 4'h1) acc = refMem[ir[11:0]];
          else                   acc = acc + refMem[ir[11:0]];
        end
        4'h2: begin
          stepWrite(ir[11:0], acc, 1'b0, "R4 store (value from R3)");
          refMem[ir[11:0]] = acc;
        end
        4'h8: begin
          stepIdle("R5 jump");
          pc = ir[11:0];
        end
        4'h9: begin
          stepRead(12'h000, "R10 restore pc read");
          stepRead(12'h001, "R10 restore acc read");
          stepIdle("R10 wait");
          stepIdle("R10 update");
          pc   = refMem[0][11:0];
          acc  = refMem[1];
          mask = 1'b0;
        end
        4'h0: begin
          modelHalted = 1'b1;
          forever stepIdle("R6 halted");
        end
        default: stepIdle("R7 no-op");
      endcase
      stepIdle("R8 interrupt phase");
      if (irqReq === 1'b1 && !mask) begin
        stepWrite(12'h000, {4'h0, pc}, 1'b1, "R8 save pc");
        refMem[0] = {4'h0, pc};
        stepWrite(12'h001, acc, 1'b0, "R8 save acc");
        refMem[1] = acc;
        pc   = 12'h010;
        mask = 1'b1;
      end
    end
  end

  // Interrupt source: second request raised while the handler is masked
  initial begin
    wait (rst === 1'b0);
    repeat (40) @(posedge clk);
    #1 irqReq = 1'b1;
    do @(negedge clk); while (irqAck !== 1'b1);
    @(posedge clk); #1 irqReq = 1'b0;
    repeat (3) @(posedge clk);
    #1 irqReq = 1'b1;
    do @(negedge clk); while (irqAck !== 1'b1);
    @(posedge clk); #1 irqReq = 1'b0;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=halted");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Main sequence
  initial begin
    int diffs;
    repeat (3) begin
      @(negedge clk);
      chk(memWe === 1'b0, "R1", "memWe in reset", 32'(memWe), 0);
      chk(irqAck === 1'b0, "R1", "irqAck in reset", 32'(irqAck), 0);
    end
    @(posedge clk);
    #1 rst = 1'b0;
    wait (modelHalted);
    repeat (20) @(negedge clk);
    chk(ackCount == 2, "R9", "acknowledge count", 32'(ackCount), 2);
    chk(ramArr[12'h180] === 16'h0002, "R10", "handler runs", 32'(ramArr[12'h180]), 2);
    chk(ramArr[12'h051] === 16'h0000, "R5", "skipped store", 32'(ramArr[12'h051]), 0);
    chk(ramArr[12'h050] === 16'h1003, "R3", "wrapped sum", 32'(ramArr[12'h050]), 32'h1003);
    diffs = 0;
    for (int i = 0; i < 4096; i++) if (ramArr[i] !== refMem[i]) diffs++;
    chk(diffs == 0, "R3", "memory image mismatches", 32'(diffs), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule